// File: doc/BRIEF.md
# Streaming Pixel Compare Unit

The unit takes two pixel streams that run in step, each carrying 8-bit unsigned single-channel grayscale samples. It compares them position by position and produces a mask stream. The relation to test is fixed when the block is built, using one of six modes. Each output pixel is 0xFF when the relation holds for that position and 0x00 when it does not. Typical uses are thresholding one image against another, change detection, and building keep/drop masks for later stages.

A beat carries either one pixel or eight adjacent pixels packed into a 64-bit word. All lanes of a beat are compared in parallel. The two inputs and the output each use a valid/ready handshake. Frame height in rows and width in pixels are run-time inputs. The block uses them to flag the last beat of each line and the last beat of each frame. Parameter sets that make no sense, such as an unknown mode, an unsupported lane count, or a maximum width that is not a whole number of beats, stop elaboration.

Top module: `pix_compare_stream`

## Requirements
- R1: Parameter `REL` selects the relation of first-stream pixel A to second-stream pixel B, using this encoding: 0 A==B, 1 A>B, 2 A>=B, 3 A<B, 4 A<=B, 5 A!=B.
- R2: Every output pixel is exactly 8'hFF when the selected relation holds for that position, and 8'h00 otherwise.
- R3: Pixels are compared as unsigned 8-bit magnitudes, so 0 is the smallest value and 255 is the largest.
- R4: `LANES` is 1 or 8. Lane i occupies bits [8i+7:8i], with lane 0 (the leftmost pixel) in the least significant byte. Output lane i depends only on lane i of both inputs.
- R5: A beat is taken from both inputs in the same cycle, and only when both are valid and the output register is empty or being accepted. `a_ready` and `b_ready` never signal a one-sided transfer. After reset, `m_valid` is low.
- R6: A result appears on the output one cycle after its inputs are taken. With both inputs valid and `m_ready` held high, one beat passes per clock with no gaps.
- R7: While `m_valid` is high and `m_ready` is low, `m_data`, `m_eol` and `m_eof` keep their values.
- R8: `m_eol` is high on the last beat of each row. A row is `cfg_width / LANES` beats long, and `cfg_width` must be a multiple of `LANES`.
- R9: `m_eof` is high on the last beat of row `cfg_rows - 1`. After that beat the line and row counts restart at zero for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rows | input | $clog2(MAX_ROWS+1) | Rows per frame |
| cfg_width | input | $clog2(MAX_WIDTH+1) | Pixels per row, a multiple of LANES |
| a_valid | input | 1 | First stream beat present |
| a_ready | output | 1 | First stream beat taken |
| a_data | input | 8*LANES | First stream packed pixels |
| b_valid | input | 1 | Second stream beat present |
| b_ready | output | 1 | Second stream beat taken |
| b_data | input | 8*LANES | Second stream packed pixels |
| m_valid | output | 1 | Mask beat present |
| m_ready | input | 1 | Mask beat accepted downstream |
| m_data | output | 8*LANES | Packed mask pixels, 0x00 or 0xFF per lane |
| m_eol | output | 1 | Last beat of a row |
| m_eof | output | 1 | Last beat of a frame |

## Verification
Some properties are checked on every cycle. The two inputs are always consumed together. Every output lane is either 0x00 or 0xFF and matches a relation evaluated on the inputs taken one cycle earlier. A stalled output beat does not change. The end-of-frame flag never appears without the end-of-line flag. The scenarios test the rest: all six modes at both lane counts, equal pairs and 0/255 boundary pairs, row and frame flags at the right positions across two frames, and a stall-free burst. The burst shows the one-cycle latency and one beat per clock, which a single-cycle property cannot confirm.

// File: rtl/pxcmp_pkg.sv
package pxcmp_pkg;

   localparam int PIX_W   = 8;
   localparam int REL_CNT = 6;

   typedef enum int {
      REL_EQ = 0,
      REL_GT = 1,
      REL_GE = 2,
      REL_LT = 3,
      REL_LE = 4,
      REL_NE = 5
   } rel_e;

   localparam logic [PIX_W-1:0] MASK_ON  = '1;
   localparam logic [PIX_W-1:0] MASK_OFF = '0;

endpackage

// File: rtl/pxcmp_lane.sv
module pxcmp_lane
   import pxcmp_pkg::*;
#(
   parameter int REL = REL_NE
) (
   input  logic [PIX_W-1:0] px_a,
   input  logic [PIX_W-1:0] px_b,
   output logic [PIX_W-1:0] px_q
);

   logic hit;

   // One comparator built per lane; the mode is resolved at elaboration.
   generate
      case (REL)
         REL_EQ: begin : g_eq
            assign hit = (px_a == px_b);
         end
         REL_GT: begin : g_gt
            assign hit = (px_a > px_b);
         end
         REL_GE: begin : g_ge
            assign hit = (px_a >= px_b);
         end
         REL_LT: begin : g_lt
            assign hit = (px_a < px_b);
         end
         REL_LE: begin : g_le
            assign hit = (px_a <= px_b);
         end
         REL_NE: begin : g_ne
            assign hit = (px_a != px_b);
         end
         default: begin : g_bad
            $error("pxcmp_lane: relation code %0d is not defined", REL);
            assign hit = 1'b0;
         end
      endcase
   endgenerate

   assign px_q = hit ? MASK_ON : MASK_OFF;

endmodule

// File: rtl/pxcmp_pos.sv
module pxcmp_pos #(
   parameter int LANES     = 8,
   parameter int MAX_ROWS  = 1080,
   parameter int MAX_WIDTH = 1920,
   localparam int RW       = $clog2(MAX_ROWS + 1),
   localparam int CW       = $clog2(MAX_WIDTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [RW-1:0] rows,
   input  logic [CW-1:0] width,
   output logic          at_eol,
   output logic          at_eof
);

   localparam int SH = $clog2(LANES);

   logic [CW-1:0] beats;
   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;

   assign beats  = width >> SH;
   assign at_eol = (col_q == beats - CW'(1));
   assign at_eof = at_eol && (row_q == rows - RW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step) begin
         if (at_eol) begin
            col_q <= '0;
            row_q <= at_eof ? '0 : row_q + RW'(1);
         end else begin
            col_q <= col_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/pxcmp_outreg.sv
module pxcmp_outreg #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d_data,
   input  logic         d_eol,
   input  logic         d_eof,
   output logic         slot_free,
   output logic         q_valid,
   input  logic         q_ready,
   output logic [W-1:0] q_data,
   output logic         q_eol,
   output logic         q_eof
);

   assign slot_free = !q_valid || q_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_data  <= '0;
         q_eol   <= 1'b0;
         q_eof   <= 1'b0;
      end else if (slot_free) begin
         q_valid <= load;
         if (load) begin
            q_data <= d_data;
            q_eol  <= d_eol;
            q_eof  <= d_eof;
         end
      end
   end

endmodule

// File: rtl/pix_compare_stream.sv
module pix_compare_stream
   import pxcmp_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int REL       = REL_NE,
   parameter int MAX_ROWS  = 1080,
   parameter int MAX_WIDTH = 1920,
   localparam int DW       = LANES * PIX_W,
   localparam int RW       = $clog2(MAX_ROWS + 1),
   localparam int CW       = $clog2(MAX_WIDTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] cfg_rows,
   input  logic [CW-1:0] cfg_width,
   input  logic          a_valid,
   output logic          a_ready,
   input  logic [DW-1:0] a_data,
   input  logic          b_valid,
   output logic          b_ready,
   input  logic [DW-1:0] b_data,
   output logic          m_valid,
   input  logic          m_ready,
   output logic [DW-1:0] m_data,
   output logic          m_eol,
   output logic          m_eof
);

   // Elaboration-time parameter checks
   generate
      if (LANES != 1 && LANES != 8) begin : g_bad_lanes
         $error("pix_compare_stream: LANES must be 1 or 8, got %0d", LANES);
      end
      if (REL < 0 || REL >= REL_CNT) begin : g_bad_rel
         $error("pix_compare_stream: REL %0d out of range", REL);
      end
      if (MAX_WIDTH % LANES != 0) begin : g_bad_width
         $error("pix_compare_stream: MAX_WIDTH not a multiple of LANES");
      end
      if (MAX_ROWS < 1 || MAX_WIDTH < 1) begin : g_bad_size
         $error("pix_compare_stream: frame limits must be positive");
      end
   endgenerate

   logic          slot_free;
   logic          take;
   logic [DW-1:0] mask;
   logic          pos_eol;
   logic          pos_eof;

   assign take    = a_valid && b_valid && slot_free;
   assign a_ready = b_valid && slot_free;
   assign b_ready = a_valid && slot_free;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         pxcmp_lane #(.REL(REL)) u_lane (
            .px_a (a_data[i*PIX_W +: PIX_W]),
            .px_b (b_data[i*PIX_W +: PIX_W]),
            .px_q (mask[i*PIX_W +: PIX_W])
         );
      end
   endgenerate

   pxcmp_pos #(
      .LANES     (LANES),
      .MAX_ROWS  (MAX_ROWS),
      .MAX_WIDTH (MAX_WIDTH)
   ) u_pos (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (take),
      .rows   (cfg_rows),
      .width  (cfg_width),
      .at_eol (pos_eol),
      .at_eof (pos_eof)
   );

   pxcmp_outreg #(.W(DW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .d_data    (mask),
      .d_eol     (pos_eol),
      .d_eof     (pos_eof),
      .slot_free (slot_free),
      .q_valid   (m_valid),
      .q_ready   (m_ready),
      .q_data    (m_data),
      .q_eol     (m_eol),
      .q_eof     (m_eof)
   );

endmodule

// File: rtl/pxcmp_chk.sv
module pxcmp_chk
   import pxcmp_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int REL       = REL_NE,
   parameter int MAX_ROWS  = 1080,
   parameter int MAX_WIDTH = 1920,
   localparam int DW       = LANES * PIX_W,
   localparam int RW       = $clog2(MAX_ROWS + 1),
   localparam int CW       = $clog2(MAX_WIDTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [RW-1:0] cfg_rows,
   input logic [CW-1:0] cfg_width,
   input logic          a_valid,
   input logic          a_ready,
   input logic [DW-1:0] a_data,
   input logic          b_valid,
   input logic          b_ready,
   input logic [DW-1:0] b_data,
   input logic          m_valid,
   input logic          m_ready,
   input logic [DW-1:0] m_data,
   input logic          m_eol,
   input logic          m_eof
);

   logic [DW-1:0] want;
   logic          bytes_ok;
   logic          a_fire;
   logic          b_fire;

   assign a_fire = a_valid && a_ready;
   assign b_fire = b_valid && b_ready;

   always_comb begin
      want     = '0;
      bytes_ok = 1'b1;
      for (int i = 0; i < LANES; i++) begin
         logic [7:0] x, y, z;
         logic       h;
         x = a_data[i*8 +: 8];
         y = b_data[i*8 +: 8];
         z = m_data[i*8 +: 8];
         case (REL)
            0:       h = (x == y);
            1:       h = (x > y);
            2:       h = (x >= y);
            3:       h = (x < y);
            4:       h = (x <= y);
            default: h = (x != y);
         endcase
         want[i*8 +: 8] = h ? 8'hFF : 8'h00;
         if (z != 8'h00 && z != 8'hFF) bytes_ok = 1'b0;
      end
   end

   // R5
   paired_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_fire |-> b_fire);

   // R5
   paired_take_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_fire |-> a_fire);

   // R6
   one_cycle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_fire |=> m_valid);

   // R1
   relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_fire |=> (m_data == $past(want)));

   // R2
   full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> bytes_ok);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=>
         (m_valid && $stable(m_data) && $stable(m_eol) && $stable(m_eof)));

   // R9
   eof_has_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_eof) |-> m_eol);

endmodule

bind pix_compare_stream pxcmp_chk #(
   .LANES     (LANES),
   .REL       (REL),
   .MAX_ROWS  (MAX_ROWS),
   .MAX_WIDTH (MAX_WIDTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rows  (cfg_rows),
   .cfg_width (cfg_width),
   .a_valid   (a_valid),
   .a_ready   (a_ready),
   .a_data    (a_data),
   .b_valid   (b_valid),
   .b_ready   (b_ready),
   .b_data    (b_data),
   .m_valid   (m_valid),
   .m_ready   (m_ready),
   .m_data    (m_data),
   .m_eol     (m_eol),
   .m_eof     (m_eof)
);

// File: tb/sim_cmp_rig.sv
module sim_cmp_rig #(
   parameter int REL   = 0,
   parameter int LANES = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_chk,
   output int   n_fail
);

   localparam int DW   = LANES * 8;
   localparam int ROWS = 3;
   localparam int BPR  = 4;
   localparam int N1   = ROWS * BPR * 2;
   localparam int NT   = N1 + ROWS * BPR;

   logic          a_valid, a_ready, b_valid, b_ready;
   logic [DW-1:0] a_data, b_data;
   logic          m_valid, m_ready, m_eol, m_eof;
   logic [DW-1:0] m_data;
   logic [4:0]    cfg_rows;
   logic [6:0]    cfg_width;

   logic [DW-1:0] av [NT];
   logic [DW-1:0] bv [NT];
   int            in_cyc  [NT];
   int            out_cyc [NT];
   int            cyc;
   logic          a_took, b_took;

   assign cfg_rows  = 5'(ROWS);
   assign cfg_width = 7'(LANES * BPR);

   pix_compare_stream #(
      .LANES(LANES), .REL(REL), .MAX_ROWS(16), .MAX_WIDTH(64)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_width(cfg_width),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
      .m_eol(m_eol), .m_eof(m_eof)
   );

   function automatic logic ref_hit(int m, logic [7:0] x, logic [7:0] y);
      int ux = int'(x);
      int uy = int'(y);
      case (m)
         0:       return ux == uy;
         1:       return ux > uy;
         2:       return ux >= uy;
         3:       return ux < uy;
         4:       return ux <= uy;
         default: return ux != uy;
      endcase
   endfunction

   initial begin
      for (int k = 0; k < NT; k++) begin
         for (int l = 0; l < LANES; l++) begin
            logic [7:0] x, y;
            x = 8'($urandom);
            y = 8'($urandom);
            case ($urandom % 8)
               0: y = x;
               1: begin x = 8'd0;   y = 8'd255; end
               2: begin x = 8'd255; y = 8'd0;   end
               3: begin x = 8'd0;   y = 8'd0;   end
               4: begin x = 8'd255; y = 8'd255; end
               5: y = x + 8'd1;
               default: ;
            endcase
            av[k][l*8 +: 8] = x;
            bv[k][l*8 +: 8] = y;
         end
      end
   end

   always @(posedge clk) begin
      cyc    <= rst_n ? cyc + 1 : 0;
      a_took <= a_valid && a_ready;
      b_took <= b_valid && b_ready;
   end

   // first-stream driver
   initial begin
      int ai = 0;
      a_valid = 1'b0;
      a_data  = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (a_took) ai++;
         if (ai >= NT) a_valid = 1'b0;
         else if (!(a_valid && !a_took)) begin
            a_valid = (ai >= N1) || ($urandom % 4 != 0);
            a_data  = av[ai];
         end
         #2;
         if (a_valid && a_ready && ai >= N1 && ai < NT) in_cyc[ai] = cyc;
      end
   end

   // second-stream driver
   initial begin
      int bi = 0;
      b_valid = 1'b0;
      b_data  = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (b_took) bi++;
         if (bi >= NT) b_valid = 1'b0;
         else if (!(b_valid && !b_took)) begin
            b_valid = (bi >= N1) || ($urandom % 3 != 0);
            b_data  = bv[bi];
         end
      end
   end

   // monitor and scoreboard
   initial begin
      int            oi = 0;
      logic          stalled = 1'b0;
      logic [DW-1:0] held = '0;
      done    = 1'b0;
      n_chk   = 0;
      n_fail  = 0;
      m_ready = 1'b0;
      @(posedge rst_n);
      @(negedge clk);
      n_chk++;
      if (m_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R5 rel=%0d lanes=%0d reset m_valid got %b exp 0", REL, LANES, m_valid);
      end
      while (!done) begin
         @(negedge clk);
         m_ready = (oi >= N1) ? 1'b1 : ($urandom % 3 != 0);
         #1;
         if (stalled && m_valid) begin
            n_chk++;
            if (m_data !== held) begin
               n_fail++;
               $display("FAIL R7 rel=%0d lanes=%0d held data got %h exp %h", REL, LANES, m_data, held);
            end
         end
         stalled = m_valid && !m_ready;
         held    = m_data;
         if (m_valid && m_ready && oi < NT) begin
            logic [DW-1:0] e;
            int            col, row;
            logic          eol_e, eof_e;
            for (int l = 0; l < LANES; l++)
               e[l*8 +: 8] = ref_hit(REL, av[oi][l*8 +: 8], bv[oi][l*8 +: 8]) ? 8'hFF : 8'h00;
            col   = oi % BPR;
            row   = (oi / BPR) % ROWS;
            eol_e = (col == BPR - 1);
            eof_e = eol_e && (row == ROWS - 1);
            n_chk++;
            if (m_data !== e) begin
               n_fail++;
               $display("FAIL R1 R2 R3 R4 rel=%0d lanes=%0d beat %0d got %h exp %h", REL, LANES, oi, m_data, e);
            end
            n_chk++;
            if (m_eol !== eol_e) begin
               n_fail++;
               $display("FAIL R8 rel=%0d lanes=%0d beat %0d eol got %b exp %b", REL, LANES, oi, m_eol, eol_e);
            end
            n_chk++;
            if (m_eof !== eof_e) begin
               n_fail++;
               $display("FAIL R9 rel=%0d lanes=%0d beat %0d eof got %b exp %b", REL, LANES, oi, m_eof, eof_e);
            end
            if (oi >= N1) out_cyc[oi] = cyc;
            oi++;
            if (oi == NT) begin
               for (int k = N1; k < NT; k++) begin
                  n_chk++;
                  if (out_cyc[k] != in_cyc[k] + 1) begin
                     n_fail++;
                     $display("FAIL R6 rel=%0d lanes=%0d latency beat %0d got %0d exp %0d",
                              REL, LANES, k, out_cyc[k] - in_cyc[k], 1);
                  end
                  if (k > N1) begin
                     n_chk++;
                     if (in_cyc[k] != in_cyc[k-1] + 1) begin
                        n_fail++;
                        $display("FAIL R6 rel=%0d lanes=%0d gap before beat %0d got %0d exp %0d",
                                 REL, LANES, k, in_cyc[k] - in_cyc[k-1], 1);
                     end
                  end
               end
               done = 1'b1;
            end
         end
      end
   end

endmodule

// File: tb/sim_pix_compare_stream.sv
module sim_pix_compare_stream;

   localparam int NR = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd [NR];
   int   rc [NR];
   int   rf [NR];

   always #4 clk = !clk;

   generate
      for (genvar gm = 0; gm < 6; gm++) begin : g_rel
         for (genvar gl = 0; gl < 2; gl++) begin : g_ln
            sim_cmp_rig #(.REL(gm), .LANES(gl == 0 ? 1 : 8)) u_rig (
               .clk    (clk),
               .rst_n  (rst_n),
               .done   (rd[gm*2+gl]),
               .n_chk  (rc[gm*2+gl]),
               .n_fail (rf[gm*2+gl])
            );
         end
      end
   endgenerate

   initial begin
      int   total = 0;
      int   bad = 0;
      int   waited = 0;
      logic all;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      all = 1'b0;
      while (!all && waited < 20000) begin
         @(negedge clk);
         waited++;
         all = 1'b1;
         for (int i = 0; i < NR; i++) if (rd[i] !== 1'b1) all = 1'b0;
      end
      for (int i = 0; i < NR; i++) begin
         total += rc[i];
         bad   += rf[i];
      end
      if (!all) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, got %0d cycles exp fewer than %0d", waited, 20000);
      end
      $display("[TB] %0d tests run, %0d failed", total, bad);
      $finish;
   end

endmodule